// File: doc/BRIEF.md
# Supplier Line Presence Predictor

This block keeps a small set-associative directory of the line addresses for which the local node currently acts as the supplier of data. When a line arrives at the node with supplier status, the surrounding logic pulses the insert port. When the node gives up that status (the line is evicted, downgraded or invalidated), it pulses the remove port. Snoop traffic asks the lookup port whether this node is likely to hold the line as supplier. A hit predicts that it does, and a miss predicts that it does not.

Only one node in the system can hold a given line as supplier. Explicit removal therefore keeps the table free of stale entries, so a hit is never wrong. When a set is full, an insert replaces the least recently used entry. The line it replaces is still held, so a later miss for that line can be wrong (a false negative). The block accepts this cost.

Addresses are line addresses, with the byte offset already stripped. The low `log2(SETS)` bits select the set and the remaining upper bits form the stored tag. Insert and remove have no back-pressure: they are accepted in every cycle in which they are valid. A lookup is a valid/ready transfer. `lk_ready` is high when no response is pending, or when the pending response is taken in the same cycle. The response register holds its value while `rsp_ready` is low.

Top module: `supplier_pred`

## Requirements
- R1: After reset, `rsp_valid` is 0, `lk_ready` is 1 and every lookup misses.
- R2: A lookup for an address that was inserted and has not since been removed or displaced hits. A lookup for an address with the same tag but a different set index (index = `addr[log2(SETS)-1:0]`) is unaffected by that insert.
- R3: A remove clears the matching entry, so a later lookup misses. A remove for an address that is not held leaves every other entry's lookup result unchanged.
- R4: While a set has an invalid way, an insert fills an invalid way, so up to WAYS distinct tags in one set all hit.
- R5: An insert into a full set replaces the least recently used entry. Recency is refreshed by inserts and by lookup hits, so a looked-up entry survives over an older one.
- R6: Inserting an address that is already held creates no second copy and evicts nothing. It only makes that entry the most recently used.
- R7: When insert and remove name the same address in the same cycle, the remove wins and the address is not held afterwards.
- R8: An accepted lookup produces `rsp_valid` = 1 on the next cycle. `rsp_hit` reflects the table as it stood before any insert or remove made in the lookup's own cycle. With `rsp_ready` = 1 and no new lookup, `rsp_valid` falls one cycle later.
- R9: While `rsp_valid` = 1 and `rsp_ready` = 0, `lk_ready` is 0, and `rsp_valid` and `rsp_hit` hold their values.
- R10: A lookup never hits for an address that is not currently held according to the sequence of inserts and removes (no false positives).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert a line that arrived with supplier status |
| ins_addr | input | ADDR_W | Line address to insert |
| rm_valid | input | 1 | Remove a line that lost supplier status |
| rm_addr | input | ADDR_W | Line address to remove |
| lk_valid | input | 1 | Lookup request valid |
| lk_addr | input | ADDR_W | Snoop line address to predict for |
| lk_ready | output | 1 | Lookup request accepted this cycle when high |
| rsp_valid | output | 1 | Prediction available |
| rsp_ready | input | 1 | Consumer takes the prediction |
| rsp_hit | output | 1 | 1 = predicted held as supplier |

## Verification
Directed sequences cover the following cases:
- Filling a single set up to its way count and checking that nothing is lost.
- Overfilling a set after refreshing selected tags by lookup or by re-insert, which separates true LRU from fill-order replacement.
- Same-cycle insert/remove of one address and lookup-with-insert in one cycle, which pin down the priority and the pre-update view.
- A stalled response, which shows the hold behaviour.

A pseudo-random mix of inserts, removes and lookups over a tag pool wider than the way count forces frequent evictions. It is compared against an arithmetic timestamp model. An exhaustive lookup over every line address at start and end shows there are no false positives or stale hits anywhere in the address space.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned SP_ADDR_W = 8;
  localparam int unsigned SP_SETS   = 4;
  localparam int unsigned SP_WAYS   = 4;

  function automatic int unsigned sp_log2(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sp_lru_ages.sv
module sp_lru_ages #(
  parameter int unsigned WAYS = 4,
  parameter int unsigned AW   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     touch_en,
  input  logic [WAYS-1:0]          touch_oh,
  output logic [WAYS-1:0][AW-1:0]  age
);
  logic [AW-1:0] touched_age;

  always_comb begin
    touched_age = '0;
    for (int w = 0; w < WAYS; w++)
      if (touch_oh[w]) touched_age = touched_age | age[w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) age[w] <= AW'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (touch_oh[w])                age[w] <= '0;
        else if (age[w] < touched_age)  age[w] <= age[w] + AW'(1);
      end
    end
  end
endmodule

// File: rtl/sp_victim_pick.sv
module sp_victim_pick #(
  parameter int unsigned WAYS = 4,
  parameter int unsigned AW   = 2
) (
  input  logic [WAYS-1:0]          vld,
  input  logic [WAYS-1:0][AW-1:0]  age,
  output logic [WAYS-1:0]          victim
);
  always_comb begin
    logic found;
    victim = '0;
    found  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vld[w] && !found) begin
        victim[w] = 1'b1;
        found     = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++)
        if (age[w] == AW'(WAYS - 1)) victim[w] = 1'b1;
    end
  end
endmodule

// File: rtl/sp_set.sv
module sp_set #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [TAG_W-1:0] ins_tag,
  input  logic             rm_en,
  input  logic [TAG_W-1:0] rm_tag,
  input  logic             lk_en,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit
);
  localparam int unsigned AW = sp_pkg::sp_log2(WAYS);

  logic [WAYS-1:0][TAG_W-1:0] tags;
  logic [WAYS-1:0]            vld;
  logic [WAYS-1:0]            ins_match, rm_match, lk_match;
  logic [WAYS-1:0]            victim, ins_way, touch_oh;
  logic [WAYS-1:0][AW-1:0]    age;
  logic                       touch_en;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign ins_match[w] = vld[w] && (tags[w] == ins_tag);
    assign rm_match[w]  = vld[w] && (tags[w] == rm_tag);
    assign lk_match[w]  = vld[w] && (tags[w] == lk_tag);
  end

  assign ins_way  = (|ins_match) ? ins_match : victim;
  assign lk_hit   = |lk_match;
  // An insert owns the recency update; a same-set lookup hit yields to it.
  assign touch_en = ins_en | (lk_en & lk_hit);
  assign touch_oh = ins_en ? ins_way : lk_match;

  sp_victim_pick #(.WAYS(WAYS), .AW(AW)) u_victim (
    .vld    (vld),
    .age    (age),
    .victim (victim)
  );

  sp_lru_ages #(.WAYS(WAYS), .AW(AW)) u_ages (
    .clk      (clk),
    .rst_n    (rst_n),
    .touch_en (touch_en),
    .touch_oh (touch_oh),
    .age      (age)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      tags <= '0;
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        if (ins_en && ins_way[w]) begin
          tags[w] <= ins_tag;
          vld[w]  <= 1'b1;
        end else if (rm_en && rm_match[w]) begin
          vld[w]  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/supplier_pred.sv
module supplier_pred #(
  parameter int unsigned ADDR_W = sp_pkg::SP_ADDR_W,
  parameter int unsigned SETS   = sp_pkg::SP_SETS,
  parameter int unsigned WAYS   = sp_pkg::SP_WAYS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              rm_valid,
  input  logic [ADDR_W-1:0] rm_addr,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] ins_idx, rm_idx, lk_idx;
  logic [TAG_W-1:0] ins_tag, rm_tag, lk_tag;
  logic             same_line, ins_eff, lk_fire;
  logic [SETS-1:0]  set_hit;

  assign ins_idx = ins_addr[IDX_W-1:0];
  assign rm_idx  = rm_addr[IDX_W-1:0];
  assign lk_idx  = lk_addr[IDX_W-1:0];
  assign ins_tag = ins_addr[ADDR_W-1:IDX_W];
  assign rm_tag  = rm_addr[ADDR_W-1:IDX_W];
  assign lk_tag  = lk_addr[ADDR_W-1:IDX_W];

  // Removal wins over a same-cycle insert of the same line.
  assign same_line = ins_valid && rm_valid && (ins_addr == rm_addr);
  assign ins_eff   = ins_valid && !same_line;

  assign lk_ready = !rsp_valid || rsp_ready;
  assign lk_fire  = lk_valid && lk_ready;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    sp_set #(.WAYS(WAYS), .TAG_W(TAG_W)) u_set (
      .clk     (clk),
      .rst_n   (rst_n),
      .ins_en  (ins_eff && (ins_idx == IDX_W'(s))),
      .ins_tag (ins_tag),
      .rm_en   (rm_valid && (rm_idx == IDX_W'(s))),
      .rm_tag  (rm_tag),
      .lk_en   (lk_fire && (lk_idx == IDX_W'(s))),
      .lk_tag  (lk_tag),
      .lk_hit  (set_hit[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else if (lk_fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= set_hit[lk_idx];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sp_checker.sv
module sp_checker (
  input logic clk,
  input logic rst_n,
  input logic lk_valid,
  input logic lk_ready,
  input logic rsp_valid,
  input logic rsp_ready,
  input logic rsp_hit
);
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit)));

  a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !lk_ready);

  a_r8_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(lk_valid && lk_ready));

  a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !lk_valid) |=> !rsp_valid);

  a_r1_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> lk_ready);
endmodule

bind supplier_pred sp_checker u_sp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_ready  (lk_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_hit   (rsp_hit)
);

// File: tb/tb_supplier_pred.sv
`timescale 1ns/1ps
module tb_supplier_pred;
  localparam int AW = 8, SETS = 4, WAYS = 4;
  localparam int IW = 2, TW = AW - IW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 0, rm_valid = 0, lk_valid = 0, rsp_ready = 1;
  logic [AW-1:0] ins_addr = '0, rm_addr = '0, lk_addr = '0;
  logic lk_ready, rsp_valid, rsp_hit;

  int n_chk = 0, n_bad = 0;

  bit           mv [SETS][WAYS];
  logic [TW-1:0] mt [SETS][WAYS];
  int           ms [SETS][WAYS];
  int           stamp = 0;
  logic [15:0]  lfsr = 16'hACE1;

  always #2 clk = ~clk;

  supplier_pred #(.ADDR_W(AW), .SETS(SETS), .WAYS(WAYS)) dut (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_addr(ins_addr),
    .rm_valid(rm_valid), .rm_addr(rm_addr),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit)
  );

  function automatic logic [AW-1:0] mk(int tag, int idx);
    return {TW'(tag), IW'(idx)};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int m_way(logic [AW-1:0] a);
    for (int w = 0; w < WAYS; w++)
      if (mv[a % SETS][w] && mt[a % SETS][w] == a[AW-1:IW]) return w;
    return -1;
  endfunction

  task automatic m_insert(logic [AW-1:0] a);
    int s = a % SETS;
    int w = m_way(a);
    if (w < 0) begin
      for (int k = WAYS - 1; k >= 0; k--) if (!mv[s][k]) w = k;
      if (w < 0) begin
        w = 0;
        for (int k = 1; k < WAYS; k++) if (ms[s][k] < ms[s][w]) w = k;
      end
    end
    mv[s][w] = 1; mt[s][w] = a[AW-1:IW]; ms[s][w] = ++stamp;
  endtask

  task automatic m_remove(logic [AW-1:0] a);
    int w = m_way(a);
    if (w >= 0) mv[a % SETS][w] = 0;
  endtask

  task automatic m_touch(logic [AW-1:0] a);
    int w = m_way(a);
    if (w >= 0) ms[a % SETS][w] = ++stamp;
  endtask

  // want < 0: expected lookup result from the model (pre-update view, R8).
  task automatic step(bit iv, logic [AW-1:0] ia, bit rv, logic [AW-1:0] ra,
                      bit lv, logic [AW-1:0] la, int want, string req);
    int exp_hit;
    bit same, ins_e;
    @(negedge clk);
    ins_valid = iv; ins_addr = ia; rm_valid = rv; rm_addr = ra;
    lk_valid = lv; lk_addr = la; rsp_ready = 1;
    exp_hit = (m_way(la) >= 0) ? 1 : 0;
    if (want >= 0 && want != exp_hit)
      chk(0, req, "model vs requirement", exp_hit, want);
    same  = iv && rv && (ia == ra);
    ins_e = iv && !same;
    @(posedge clk);
    if (lv && exp_hit && !(ins_e && (ia % SETS) == (la % SETS))) m_touch(la);
    if (ins_e) m_insert(ia);
    if (rv) m_remove(ra);
    @(negedge clk);
    ins_valid = 0; rm_valid = 0; lk_valid = 0;
    if (lv) begin
      chk(rsp_valid == 1'b1, req, "rsp_valid", int'(rsp_valid), 1);
      chk(rsp_hit == exp_hit[0], req, "rsp_hit", int'(rsp_hit), exp_hit);
    end
  endtask

  task automatic look(logic [AW-1:0] a, int want, string req);
    step(0, '0, 0, '0, 1, a, want, req);
  endtask

  task automatic ins(logic [AW-1:0] a);
    step(1, a, 0, '0, 0, '0, -1, "");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin mv[s][w] = 0; mt[s][w] = '0; ms[s][w] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1: idle outputs and empty table
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
    chk(lk_ready == 1'b1, "R1", "lk_ready after reset", int'(lk_ready), 1);
    for (int a = 0; a < (1 << AW); a++) look(AW'(a), 0, "R1");

    // R2: insert then hit; other set with same tag misses
    ins(mk(3, 1));
    look(mk(3, 1), 1, "R2");
    look(mk(3, 2), 0, "R2");
    // R3: remove, and remove of an absent line
    ins(mk(7, 1));
    step(0, '0, 1, mk(3, 1), 0, '0, -1, "R3");
    look(mk(3, 1), 0, "R3");
    step(0, '0, 1, mk(9, 1), 0, '0, -1, "R3");
    look(mk(7, 1), 1, "R3");
    // R4: fill one set up to WAYS
    for (int t = 10; t < 14; t++) ins(mk(t, 2));
    for (int t = 10; t < 14; t++) look(mk(t, 2), 1, "R4");
    // R5: refresh 10 by lookup, overflow evicts 11
    look(mk(10, 2), 1, "R5");
    ins(mk(14, 2));
    look(mk(11, 2), 0, "R5");
    look(mk(10, 2), 1, "R5");
    look(mk(14, 2), 1, "R5");
    // R6: re-insert refreshes, no duplicate
    for (int t = 20; t < 24; t++) ins(mk(t, 3));
    ins(mk(20, 3));
    ins(mk(24, 3));
    look(mk(20, 3), 1, "R6");
    look(mk(21, 3), 0, "R6");
    look(mk(22, 3), 1, "R6");
    // R7: same-cycle insert/remove of one line
    step(1, mk(30, 0), 1, mk(30, 0), 0, '0, -1, "R7");
    look(mk(30, 0), 0, "R7");
    ins(mk(31, 0));
    step(1, mk(31, 0), 1, mk(31, 0), 0, '0, -1, "R7");
    look(mk(31, 0), 0, "R7");
    // R8: lookup sees pre-update table; response drains
    step(1, mk(40, 0), 0, '0, 1, mk(40, 0), 0, "R8");
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8", "rsp_valid drained", int'(rsp_valid), 0);
    look(mk(40, 0), 1, "R8");

    // R9: stalled response
    @(negedge clk);
    rsp_ready = 0; lk_valid = 1; lk_addr = mk(10, 2);
    @(posedge clk); m_touch(mk(10, 2));
    @(negedge clk);
    lk_addr = mk(11, 2);
    chk(lk_ready == 1'b0, "R9", "lk_ready while stalled", int'(lk_ready), 0);
    chk(rsp_valid == 1'b1 && rsp_hit == 1'b1, "R9", "held hit", int'(rsp_hit), 1);
    @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_hit == 1'b1, "R9", "still held", int'(rsp_hit), 1);
    rsp_ready = 1;
    @(negedge clk);
    lk_valid = 0;
    chk(rsp_valid == 1'b1 && rsp_hit == 1'b0, "R9", "next response", int'(rsp_hit), 0);

    // R10: pseudo-random mix against the model
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a1, a2, a3;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a1 = {TW'(lfsr[4:2]), lfsr[1:0]};
      a2 = {TW'(lfsr[10:8]), lfsr[7:6]};
      a3 = {TW'(lfsr[15:13]), lfsr[12:11]};
      step(lfsr[5], a1, lfsr[11] & lfsr[3], a2, 1, a3, -1, "R10");
    end
    for (int a = 0; a < (1 << AW); a++) look(AW'(a), -1, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule